// File: doc/BRIEF.md
# Read Credit Limiter with Reply Buffer

This block sits on the requester side of a pipelined memory port whose read replies cannot be stalled. A read reply arrives as a one-cycle strobe with its data and must be taken in that same cycle. The block accepts memory requests from a user through a valid/ready handshake and forwards them to the memory. It captures every reply into a small buffer and hands the buffered data back to the user through a second valid/ready stream.

To make sure no reply can ever find the buffer full, the block keeps a pool of read credits, one per buffer slot. The pool starts full after reset. Every read the memory accepts takes one credit, and every entry the user drains from the buffer gives one back. When the pool is empty, reads are held at the user side until a credit returns. Writes never produce a reply, so they are forwarded whatever the credit count. Replies come back in request order, and the buffer keeps that order.

Back-pressure rules. On the request stream, a transfer happens in a cycle where `usr_req_valid` and `usr_req_ready` are both high. `usr_req_ready` never depends on `usr_req_valid`, but for a read it does depend on `usr_req_wr`. On the reply stream, a transfer happens when `out_valid` and `out_ready` are both high. While `out_ready` is low, the presented entry stays put.

Top module: `read_credit_limiter`

## Requirements
- R1: Reset is synchronous and active high. After reset, `out_valid` and `overflow_err` are 0 and the credit pool holds DEPTH credits, so a read is offered with `usr_req_ready` equal to `mem_rdy`.
- R2: `mem_req` is high when `usr_req_valid` is high and either the request is a write or at least one credit is left. In the same cycle, `mem_write`, `mem_addr`, `mem_wdata` and `mem_wmask` are copies of the user fields. A `mem_wmask` bit of 1 keeps the matching byte unwritten.
- R3: `usr_req_ready` equals `mem_rdy` AND (`usr_req_wr` OR credits > 0). A request counts as accepted only when `mem_req` and `mem_rdy` are both high.
- R4: An accepted read takes one credit, and a reply-stream transfer gives one back. When both happen in the same cycle, the credit count is unchanged.
- R5: With zero credits, a read is not forwarded (`mem_req` = 0, `usr_req_ready` = 0). A write is still forwarded.
- R6: Each cycle with `mem_rstb` high stores `mem_rdata` in the buffer. `out_valid` rises in the cycle after the first stored entry. Entries leave on `out_data` in arrival order.
- R7: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high and `out_data` unchanged.
- R8: `overflow_err` is a flag that stays set once set, until reset. It is set when `mem_rstb` is high while the buffer holds DEPTH entries. Under correct operation it stays 0.
- R9: A read offered while `mem_rdy` is low consumes no credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| usr_req_valid | input | 1 | User request valid |
| usr_req_ready | output | 1 | Request taken this cycle when valid is also high |
| usr_req_wr | input | 1 | 1 = write, 0 = read |
| usr_req_addr | input | ADDR_W | Word address |
| usr_req_wdata | input | DATA_W | Write data |
| usr_req_mask | input | DATA_W/8 | Per-byte write mask, 1 = leave byte |
| mem_rdy | input | 1 | Memory can take a request this cycle |
| mem_req | output | 1 | Request to memory |
| mem_write | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Address to memory |
| mem_wdata | output | DATA_W | Write data to memory |
| mem_wmask | output | DATA_W/8 | Write mask to memory |
| mem_rstb | input | 1 | Read reply strobe |
| mem_rdata | input | DATA_W | Read reply data |
| out_valid | output | 1 | Buffered reply available |
| out_ready | input | 1 | User takes the reply |
| out_data | output | DATA_W | Oldest buffered reply |
| overflow_err | output | 1 | Sticky flag: reply arrived with the buffer full |

## Verification
The bench drives reads until the credit pool runs dry. This separates a limiter that counts credits from one that stops one read early or one read late. It also mixes replies and drains so that a take and a give land in the same cycle, which catches an update that only applies one of them. Reads are offered while `mem_rdy` is low to show that a refused request costs nothing. Writes are sent while the pool is empty to show that they bypass the count. Replies are stacked up while the user is stalled and then drained one by one, which checks the stored order and that the presented entry holds during a stall.

// File: rtl/rcl_pkg.sv
`timescale 1ns/1ps
package rcl_pkg;

  // Action applied to the credit pool in one cycle
  typedef enum logic [1:0] {
    CR_HOLD = 2'd0,
    CR_TAKE = 2'd1,
    CR_GIVE = 2'd2
  } credit_op_e;

  // Action applied to the reply buffer level in one cycle
  typedef enum logic [1:0] {
    LV_KEEP = 2'd0,
    LV_FILL = 2'd1,
    LV_DRAIN = 2'd2
  } level_op_e;

endpackage

// File: rtl/rcl_credit_ctr.sv
`timescale 1ns/1ps
module rcl_credit_ctr
  import rcl_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             take,
  input  logic                             give,
  output logic [$clog2(DEPTH+1)-1:0]       credit,
  output logic                             has_credit
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_POOL = CW'(DEPTH);

  credit_op_e op;

  always_comb begin
    unique case ({take, give})
      2'b10:   op = CR_TAKE;
      2'b01:   op = CR_GIVE;
      default: op = CR_HOLD;   // neither, or both cancel out
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      credit <= FULL_POOL;
    end else begin
      unique case (op)
        CR_TAKE: credit <= credit - 1'b1;
        CR_GIVE: credit <= credit + 1'b1;
        default: credit <= credit;
      endcase
    end
  end

  assign has_credit = (credit != '0);

  AST_CREDIT_MAX: assert property (@(posedge clk) disable iff (rst)
    credit <= FULL_POOL);  // R4
  AST_CREDIT_BOTH: assert property (@(posedge clk) disable iff (rst)
    (take && give) |=> $stable(credit));  // R4
  AST_CREDIT_TAKE: assert property (@(posedge clk) disable iff (rst)
    (take && !give) |=> (credit == $past(credit) - 1'b1));  // R4
  AST_NO_TAKE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    take |-> has_credit);  // R5

endmodule

// File: rtl/rcl_req_gate.sv
`timescale 1ns/1ps
module rcl_req_gate #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                    usr_req_valid,
  input  logic                    usr_req_wr,
  input  logic [ADDR_W-1:0]       usr_req_addr,
  input  logic [DATA_W-1:0]       usr_req_wdata,
  input  logic [DATA_W/8-1:0]     usr_req_mask,
  input  logic                    has_credit,
  input  logic                    mem_rdy,
  output logic                    usr_req_ready,
  output logic                    mem_req,
  output logic                    mem_write,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic [DATA_W/8-1:0]     mem_wmask,
  output logic                    read_taken
);
  localparam int MASK_W = DATA_W / 8;

  logic may_issue;

  // A write never needs a credit; a read needs one free slot.
  assign may_issue     = usr_req_wr | has_credit;
  assign mem_req       = usr_req_valid & may_issue;
  // mem_rdy does not depend on mem_req, so it is used combinationally here.
  assign usr_req_ready = mem_rdy & may_issue;
  assign read_taken    = mem_req & mem_rdy & ~usr_req_wr;

  assign mem_write = usr_req_wr;
  assign mem_addr  = usr_req_addr;
  assign mem_wdata = usr_req_wdata;
  assign mem_wmask = MASK_W'(usr_req_mask);

endmodule

// File: rtl/rcl_reply_fifo.sv
`timescale 1ns/1ps
module rcl_reply_fifo
  import rcl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [DATA_W-1:0]  push_data,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data,
  output logic               pop,
  output logic               overflow_err
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [IW-1:0]           wr_idx;
  logic [IW-1:0]           rd_idx;
  logic [CW-1:0]           level;
  logic                    full;
  logic                    store;
  logic [DEPTH*DATA_W-1:0] slots_flat;
  level_op_e               lop;

  assign full      = (level == FULL_LVL);
  assign out_valid = (level != '0);
  assign pop       = out_valid & out_ready;
  assign store     = push & ~full;

  // One register per slot; only the slot under the write index loads.
  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (store && (wr_idx == IW'(e))) begin
        q <= push_data;
      end
    end
    assign slots_flat[e*DATA_W +: DATA_W] = q;
  end

  assign out_data = slots_flat[rd_idx*DATA_W +: DATA_W];

  always_comb begin
    unique case ({store, pop})
      2'b10:   lop = LV_FILL;
      2'b01:   lop = LV_DRAIN;
      default: lop = LV_KEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx       <= '0;
      rd_idx       <= '0;
      level        <= '0;
      overflow_err <= 1'b0;
    end else begin
      if (store) begin
        wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
      end
      if (pop) begin
        rd_idx <= (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
      end
      unique case (lop)
        LV_FILL:  level <= level + 1'b1;
        LV_DRAIN: level <= level - 1'b1;
        default:  level <= level;
      endcase
      if (push && full) begin
        overflow_err <= 1'b1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !(push && full));  // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R7
  AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_LVL);  // R6
  AST_PUSH_SHOWS: assert property (@(posedge clk) disable iff (rst)
    push |=> out_valid);  // R6

endmodule

// File: rtl/read_credit_limiter.sv
`timescale 1ns/1ps
module read_credit_limiter #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  usr_req_valid,
  output logic                  usr_req_ready,
  input  logic                  usr_req_wr,
  input  logic [ADDR_W-1:0]     usr_req_addr,
  input  logic [DATA_W-1:0]     usr_req_wdata,
  input  logic [DATA_W/8-1:0]   usr_req_mask,
  input  logic                  mem_rdy,
  output logic                  mem_req,
  output logic                  mem_write,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [DATA_W/8-1:0]   mem_wmask,
  input  logic                  mem_rstb,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [DATA_W-1:0]     out_data,
  output logic                  overflow_err
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          has_credit;
  logic          read_taken;
  logic          pop;
  logic [CW-1:0] credit;

  rcl_req_gate #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_gate (
    .usr_req_valid (usr_req_valid),
    .usr_req_wr    (usr_req_wr),
    .usr_req_addr  (usr_req_addr),
    .usr_req_wdata (usr_req_wdata),
    .usr_req_mask  (usr_req_mask),
    .has_credit    (has_credit),
    .mem_rdy       (mem_rdy),
    .usr_req_ready (usr_req_ready),
    .mem_req       (mem_req),
    .mem_write     (mem_write),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_wmask     (mem_wmask),
    .read_taken    (read_taken)
  );

  rcl_credit_ctr #(
    .DEPTH (DEPTH)
  ) u_credit (
    .clk        (clk),
    .rst        (rst),
    .take       (read_taken),
    .give       (pop),
    .credit     (credit),
    .has_credit (has_credit)
  );

  rcl_reply_fifo #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_fifo (
    .clk          (clk),
    .rst          (rst),
    .push         (mem_rstb),
    .push_data    (mem_rdata),
    .out_ready    (out_ready),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .pop          (pop),
    .overflow_err (overflow_err)
  );

  AST_READ_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_write) |-> (credit != '0));  // R5
  AST_WRITE_PASSES: assert property (@(posedge clk) disable iff (rst)
    (usr_req_valid && usr_req_wr) |-> mem_req);  // R5
  AST_REFUSED_FREE: assert property (@(posedge clk) disable iff (rst)
    (usr_req_valid && !usr_req_wr && !mem_rdy && !pop) |=> $stable(credit));  // R9
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !overflow_err);  // R8

endmodule

// File: tb/test_read_credit_limiter.sv
`timescale 1ns/1ps
module test_read_credit_limiter;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 4;
  localparam int NVEC   = 17;

  logic clk = 1'b0;
  logic rst;
  logic usr_req_valid, usr_req_ready, usr_req_wr;
  logic [ADDR_W-1:0] usr_req_addr;
  logic [DATA_W-1:0] usr_req_wdata;
  logic [DATA_W/8-1:0] usr_req_mask;
  logic mem_rdy, mem_req, mem_write;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W/8-1:0] mem_wmask;
  logic mem_rstb;
  logic [DATA_W-1:0] mem_rdata;
  logic out_valid, out_ready, overflow_err;
  logic [DATA_W-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  read_credit_limiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) i_read_credit_limiter (
    .clk(clk), .rst(rst),
    .usr_req_valid(usr_req_valid), .usr_req_ready(usr_req_ready), .usr_req_wr(usr_req_wr),
    .usr_req_addr(usr_req_addr), .usr_req_wdata(usr_req_wdata), .usr_req_mask(usr_req_mask),
    .mem_rdy(mem_rdy), .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .mem_rstb(mem_rstb), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .overflow_err(overflow_err)
  );

  // Stimulus {valid, wr, rdy, rstb, rdata[7:0], out_ready} and
  // expectation {mem_req, usr_req_ready, out_valid, out_data[7:0]}, 24 bits.
  localparam logic [23:0] VEC [NVEC] = '{
    {4'b1010, 8'h00, 1'b0, 3'b110, 8'h00},  // 0  read taken, credits 4->3 (R2 R3)
    {4'b1000, 8'h00, 1'b0, 3'b100, 8'h00},  // 1  rdy low: refused, no credit used (R9)
    {4'b1010, 8'h00, 1'b0, 3'b110, 8'h00},  // 2  3->2
    {4'b1010, 8'h00, 1'b0, 3'b110, 8'h00},  // 3  2->1
    {4'b1011, 8'hA1, 1'b0, 3'b110, 8'h00},  // 4  1->0, reply A1 stored (R6)
    {4'b1011, 8'hA2, 1'b0, 3'b001, 8'hA1},  // 5  read blocked at zero credit (R5)
    {4'b1111, 8'hA3, 1'b0, 3'b111, 8'hA1},  // 6  write passes at zero credit (R5), hold A1 (R7)
    {4'b0011, 8'hA4, 1'b0, 3'b001, 8'hA1},  // 7  buffer now full, still held (R7)
    {4'b1010, 8'h00, 1'b1, 3'b001, 8'hA1},  // 8  blocked; pop gives 1 credit (R4)
    {4'b1010, 8'h00, 1'b1, 3'b111, 8'hA2},  // 9  take and give together (R4)
    {4'b1010, 8'h00, 1'b0, 3'b111, 8'hA3},  // 10 credit 1->0
    {4'b1010, 8'h00, 1'b0, 3'b001, 8'hA3},  // 11 credit 0 proves R4 same-cycle hold
    {4'b0010, 8'h00, 1'b1, 3'b001, 8'hA3},  // 12 pop A3
    {4'b0011, 8'hA5, 1'b1, 3'b011, 8'hA4},  // 13 reply and pop same cycle (R6)
    {4'b0011, 8'hA6, 1'b1, 3'b011, 8'hA5},  // 14
    {4'b0010, 8'h00, 1'b1, 3'b011, 8'hA6},  // 15
    {4'b0010, 8'h00, 1'b0, 3'b010, 8'h00}   // 16 empty, all credits back (R4)
  };

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic wr, input logic rdy, input logic rs,
                       input logic [DATA_W-1:0] rd, input logic ordy, input int tag);
    @(negedge clk);
    usr_req_valid = v; usr_req_wr = wr; mem_rdy = rdy; mem_rstb = rs;
    mem_rdata = rd; out_ready = ordy;
    usr_req_addr  = ADDR_W'(tag);
    usr_req_wdata = DATA_W'(tag * 3);
    usr_req_mask  = 4'b0101;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0, 0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0, 0);
    rst = 1'b0;
    // reset state
    drive(1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0, 0);
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 overflow_err", 32'(overflow_err), 32'd0);
    chk("R1 ready with full pool", 32'(usr_req_ready), 32'd1);
    usr_req_valid = 1'b0;
    #0.1;

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [23:0] w;
      w = VEC[i];
      drive(w[23], w[22], w[21], w[20], DATA_W'(w[19:12]), w[11], 100 + i);
      chk("R2 R5 mem_req", 32'(mem_req), 32'(w[10]));
      chk("R3 usr_req_ready", 32'(usr_req_ready), 32'(w[9]));
      chk("R6 out_valid", 32'(out_valid), 32'(w[8]));
      if (w[8]) chk("R6 R7 out_data", out_data, DATA_W'(w[7:0]));
      if (w[10]) begin
        chk("R2 mem_addr", 32'(mem_addr), 32'(100 + i));
        chk("R2 mem_write", 32'(mem_write), 32'(w[22]));
        chk("R2 mem_wdata", mem_wdata, DATA_W'((100 + i) * 3));
        chk("R2 mem_wmask", 32'(mem_wmask), 32'h5);
      end
    end

    // Exhaust the pool: DEPTH reads go, the next is held (R4, R5)
    for (int k = 0; k < DEPTH; k++) begin
      drive(1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0, k);
      chk("R4 read accepted while credit left", 32'(usr_req_ready), 32'd1);
    end
    drive(1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0, 9);
    chk("R5 read held at zero credit, mem_req", 32'(mem_req), 32'd0);
    chk("R5 read held at zero credit, ready", 32'(usr_req_ready), 32'd0);
    drive(1'b1, 1'b1, 1'b1, 1'b0, '0, 1'b0, 9);
    chk("R5 write forwarded at zero credit", 32'(mem_req), 32'd1);
    // Replies stack up while the user stalls
    for (int k = 0; k < DEPTH; k++) begin
      drive(1'b0, 1'b0, 1'b1, 1'b1, DATA_W'(32'hB000 + k), 1'b0, 0);
    end
    // Drain in order (R6)
    for (int k = 0; k < DEPTH; k++) begin
      drive(1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b1, 0);
      chk("R6 in-order drain", out_data, DATA_W'(32'hB000 + k));
    end
    drive(1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0, 0);
    chk("R6 empty after drain", 32'(out_valid), 32'd0);
    chk("R8 overflow_err stays low", 32'(overflow_err), 32'd0);

    // Reset in mid-flow restores the pool and empties the buffer (R1)
    drive(1'b1, 1'b0, 1'b1, 1'b1, 32'hC0, 1'b0, 1);
    drive(1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0, 0);
    chk("R6 pending entry before reset", 32'(out_valid), 32'd1);
    rst = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 1'b0, '0, 1'b0, 0);
    rst = 1'b0;
    drive(1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0, 0);
    chk("R1 out_valid cleared by reset", 32'(out_valid), 32'd0);
    for (int k = 1; k < DEPTH; k++) begin
      drive(1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0, k);
      chk("R1 pool refilled by reset", 32'(usr_req_ready), 32'd1);
    end
    drive(1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0, 5);
    chk("R1 pool holds exactly DEPTH after reset", 32'(usr_req_ready), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule